// File: doc/BRIEF.md
# Bit-Addressable Memory Access Unit

This unit gives single-bit reads and writes on a byte-wide internal data store of 256 locations. The lower half of the store holds general data RAM and the upper half holds special registers. A requester gives an 8-bit bit address and an operation code. The unit works out which byte holds that bit and which bit of the byte it is. It then reads the byte over a synchronous memory port and, where the operation calls for it, writes the byte back with only that one bit changed. When the operation is complete it returns the bit's previous value and raises a one-cycle done strobe.

Bit addresses fall into two regions. In the lower region, sixteen consecutive RAM bytes hold 128 bits packed densely. In the upper region, each group of eight bit addresses maps onto one register whose byte address is a multiple of eight. The operations are read, set, clear, complement, write-carry and an atomic test-and-clear. Test-and-clear skips its write when the bit is already zero.

The memory read latency is a parameter, so the unit can sit in front of a store with one or more cycles of read pipeline.

Top module: `bitmem_access_unit`

## Requirements
- R1: After reset, req_ready is 1, and done, mem_rd_en and mem_wr_en are 0.
- R2: A bit address with bit 7 clear selects byte 0x20 + bits 6:3 of the address. Bits 2:0 give the bit index within that byte, where index 0 is the least significant bit.
- R3: A bit address with bit 7 set selects the byte made of address bits 7:3 followed by three zero bits. Bits 2:0 give the bit index.
- R4: Op code 0 (read) returns the addressed bit on bit_out and performs no write. done goes high in the cycle after the (RD_LAT+1)-th rising edge that follows the accepting edge.
- R5: Op code 1 (set) returns the old bit, writes the bit as 1 and leaves the other bits of the byte unchanged. done follows RD_LAT+2 edges after acceptance.
- R6: Op code 2 (clear) returns the old bit and writes the bit as 0. The other bits of the byte are unchanged.
- R7: Op code 3 (complement) returns the old bit and writes its inverse. The other bits of the byte are unchanged.
- R8: Op code 4 (write carry) stores req_carry into the bit. req_carry is sampled at the accepting edge.
- R9: Op code 5 (test-and-clear) on a bit that holds 1 returns 1 and writes the bit as 0. It has the latency of a modifying operation.
- R10: Op code 5 on a bit that holds 0 returns 0 and issues no write. It has the latency of a read.
- R11: req_ready is low from the accepting edge until done, and a request presented in that window is ignored. req_ready is high again in the cycle after done.
- R12: Op codes 6 and 7 behave exactly like a read.
- R13: Each operation issues exactly one read, to the mapped byte. Any write it issues goes to that same byte. A read and a write are never issued in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle and able to accept a request |
| req_op | input | 3 | Operation code |
| req_bit_addr | input | BIT_AW | Bit address |
| req_carry | input | 1 | Value stored by write-carry |
| done | output | 1 | One-cycle completion strobe |
| bit_out | output | 1 | Previous value of the addressed bit, valid while done is high |
| mem_addr | output | BIT_AW | Byte address to the memory |
| mem_rd_en | output | 1 | Memory read request |
| mem_wr_en | output | 1 | Memory write request |
| mem_wdata | output | BYTE_W | Byte to write |
| mem_rdata | input | BYTE_W | Read data, valid RD_LAT cycles after mem_rd_en |

## Verification
The bench builds the unit with RD_LAT set to 2 and the other parameters at their defaults. With a RAM base of 0x20, the address mapper uses its concatenation variant, and the read latency of 2 brings the wait-state counter into use rather than the single-cycle path. The longer busy window also lets the bench hold a second request for several cycles while an operation is in flight. A memory model in the bench delays read data by the same two cycles.

// File: rtl/bitmem_pkg.sv
`timescale 1ns/1ps
package bitmem_pkg;

   typedef enum logic [2:0] {
      BOP_READ   = 3'd0,
      BOP_SET    = 3'd1,
      BOP_CLR    = 3'd2,
      BOP_CPL    = 3'd3,
      BOP_WCARRY = 3'd4,
      BOP_TCLR   = 3'd5,
      BOP_RSV6   = 3'd6,
      BOP_RSV7   = 3'd7
   } bop_e;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_RD   = 3'd1,
      ST_WAIT = 3'd2,
      ST_WR   = 3'd3,
      ST_DONE = 3'd4
   } acc_state_e;

   // Operations that always write back, whatever the old bit was
   function automatic logic bop_always_writes(input bop_e op);
      return (op == BOP_SET) || (op == BOP_CLR) || (op == BOP_CPL) || (op == BOP_WCARRY);
   endfunction

endpackage

// File: rtl/bitmem_addr_map.sv
`timescale 1ns/1ps
module bitmem_addr_map #(
   parameter int BIT_AW   = 8,
   parameter int BYTE_W   = 8,
   parameter int RAM_BASE = 32
) (
   input  logic [BIT_AW-1:0]         bit_addr,
   output logic [BIT_AW-1:0]         byte_addr,
   output logic [$clog2(BYTE_W)-1:0] bit_idx,
   output logic                      upper
);
   localparam int IDX_W = $clog2(BYTE_W);
   localparam int ROW_W = BIT_AW - 1 - IDX_W;
   localparam int ROWS  = 2 ** ROW_W;
   localparam logic [BIT_AW-1:0] BASE = BIT_AW'(RAM_BASE);

   // elaboration-time parameter checks
   if (ROW_W < 1) begin : g_bad_width
      $error("bitmem_addr_map: BIT_AW too small for BYTE_W");
   end
   if (RAM_BASE < 0 || RAM_BASE + ROWS > 2 ** (BIT_AW - 1)) begin : g_bad_base
      $error("bitmem_addr_map: packed RAM rows overlap the register half");
   end

   logic [ROW_W-1:0]  row;
   logic [BIT_AW-1:0] ram_byte;

   assign row = bit_addr[BIT_AW-2:IDX_W];

   // aligned base: row bits simply replace the low base bits; otherwise add
   if ((RAM_BASE % ROWS) == 0) begin : g_concat
      assign ram_byte = {BASE[BIT_AW-1:ROW_W], row};
   end else begin : g_adder
      assign ram_byte = BASE + BIT_AW'(row);
   end

   always_comb begin
      upper   = bit_addr[BIT_AW-1];
      bit_idx = bit_addr[IDX_W-1:0];
      if (upper) begin
         byte_addr = {bit_addr[BIT_AW-1:IDX_W], {IDX_W{1'b0}}};
      end else begin
         byte_addr = ram_byte;
      end
   end

endmodule

// File: rtl/bitmem_modify.sv
`timescale 1ns/1ps
module bitmem_modify
   import bitmem_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic [BYTE_W-1:0]         old_byte,
   input  logic [$clog2(BYTE_W)-1:0] idx,
   input  bop_e                      op,
   input  logic                      carry,
   output logic [BYTE_W-1:0]         new_byte,
   output logic                      old_bit,
   output logic                      wr_need
);
   localparam int IDX_W = $clog2(BYTE_W);

   logic new_bit;

   always_comb begin
      old_bit = old_byte[idx];
      unique case (op)
         BOP_SET:    new_bit = 1'b1;
         BOP_CLR:    new_bit = 1'b0;
         BOP_CPL:    new_bit = ~old_bit;
         BOP_WCARRY: new_bit = carry;
         BOP_TCLR:   new_bit = 1'b0;
         default:    new_bit = old_bit;
      endcase
      wr_need = bop_always_writes(op) || ((op == BOP_TCLR) && old_bit);
   end

   // one lane per bit of the byte: only the selected lane takes the new value
   for (genvar g = 0; g < BYTE_W; g++) begin : g_lane
      assign new_byte[g] = (idx == IDX_W'(g)) ? new_bit : old_byte[g];
   end

endmodule

// File: rtl/bitmem_ctrl.sv
`timescale 1ns/1ps
module bitmem_ctrl
   import bitmem_pkg::*;
#(
   parameter int RD_LAT = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic wr_need,
   output logic ready,
   output logic rd_en,
   output logic capture,
   output logic wr_en,
   output logic done
);
   if (RD_LAT < 1) begin : g_bad_lat
      $error("bitmem_ctrl: RD_LAT must be at least 1");
   end

   acc_state_e st, st_nx;
   logic       lat_hit;

   if (RD_LAT == 1) begin : g_lat_one
      assign lat_hit = 1'b1;
   end else begin : g_lat_cnt
      localparam int CW = $clog2(RD_LAT + 1);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt <= '0;
         end else if (st == ST_RD) begin
            cnt <= CW'(1);
         end else if (st == ST_WAIT && !lat_hit) begin
            cnt <= cnt + CW'(1);
         end
      end
      assign lat_hit = (cnt == CW'(RD_LAT));
   end

   always_comb begin
      st_nx = st;
      unique case (st)
         ST_IDLE: if (start) st_nx = ST_RD;
         ST_RD:   st_nx = ST_WAIT;
         ST_WAIT: if (lat_hit) st_nx = wr_need ? ST_WR : ST_DONE;
         ST_WR:   st_nx = ST_DONE;
         ST_DONE: st_nx = ST_IDLE;
         default: st_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= ST_IDLE;
      else        st <= st_nx;
   end

   assign ready   = (st == ST_IDLE);
   assign rd_en   = (st == ST_RD);
   assign capture = (st == ST_WAIT) && lat_hit;
   assign wr_en   = (st == ST_WR);
   assign done    = (st == ST_DONE);

   assert_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !ready) else $error("accepted request left ready high");

   assert_done_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> ready) else $error("ready not back after done");

   assert_excl_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_en && wr_en)) else $error("read and write in one cycle");

   assert_wr_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> done) else $error("write not followed by done");

endmodule

// File: rtl/bitmem_access_unit.sv
`timescale 1ns/1ps
module bitmem_access_unit
   import bitmem_pkg::*;
#(
   parameter int BIT_AW   = 8,
   parameter int BYTE_W   = 8,
   parameter int RAM_BASE = 32,
   parameter int RD_LAT   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [2:0]        req_op,
   input  logic [BIT_AW-1:0] req_bit_addr,
   input  logic              req_carry,
   output logic              done,
   output logic              bit_out,
   output logic [BIT_AW-1:0] mem_addr,
   output logic              mem_rd_en,
   output logic              mem_wr_en,
   output logic [BYTE_W-1:0] mem_wdata,
   input  logic [BYTE_W-1:0] mem_rdata
);
   localparam int IDX_W = $clog2(BYTE_W);
   localparam int ROWS  = 2 ** (BIT_AW - 1 - IDX_W);

   if (BYTE_W < 2 || (2 ** IDX_W) != BYTE_W) begin : g_bad_byte
      $error("bitmem_access_unit: BYTE_W must be a power of two");
   end

   logic              start;
   logic [BIT_AW-1:0] map_byte;
   logic [IDX_W-1:0]  map_idx;
   logic              map_upper;

   bop_e              op_q;
   logic              carry_q;
   logic              upper_q;
   logic [BIT_AW-1:0] addr_q;
   logic [IDX_W-1:0]  idx_q;
   logic [BYTE_W-1:0] rbyte_q;
   logic [BYTE_W-1:0] wbyte_q;
   logic              bit_q;

   logic              capture;
   logic              wr_need;
   logic              mod_old_bit;
   logic [BYTE_W-1:0] mod_byte;

   assign start = req_valid && req_ready;

   bitmem_addr_map #(
      .BIT_AW   (BIT_AW),
      .BYTE_W   (BYTE_W),
      .RAM_BASE (RAM_BASE)
   ) u_map (
      .bit_addr  (req_bit_addr),
      .byte_addr (map_byte),
      .bit_idx   (map_idx),
      .upper     (map_upper)
   );

   // request latch
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q    <= BOP_READ;
         carry_q <= 1'b0;
         upper_q <= 1'b0;
         addr_q  <= '0;
         idx_q   <= '0;
      end else if (start) begin
         op_q    <= bop_e'(req_op);
         carry_q <= req_carry;
         upper_q <= map_upper;
         addr_q  <= map_byte;
         idx_q   <= map_idx;
      end
   end

   bitmem_modify #(
      .BYTE_W (BYTE_W)
   ) u_mod (
      .old_byte (mem_rdata),
      .idx      (idx_q),
      .op       (op_q),
      .carry    (carry_q),
      .new_byte (mod_byte),
      .old_bit  (mod_old_bit),
      .wr_need  (wr_need)
   );

   // read-data capture
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rbyte_q <= '0;
         wbyte_q <= '0;
         bit_q   <= 1'b0;
      end else if (capture) begin
         rbyte_q <= mem_rdata;
         wbyte_q <= mod_byte;
         bit_q   <= mod_old_bit;
      end
   end

   bitmem_ctrl #(
      .RD_LAT (RD_LAT)
   ) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .wr_need (wr_need),
      .ready   (req_ready),
      .rd_en   (mem_rd_en),
      .capture (capture),
      .wr_en   (mem_wr_en),
      .done    (done)
   );

   assign mem_addr  = addr_q;
   assign mem_wdata = wbyte_q;
   assign bit_out   = bit_q;

   assert_ram_rows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_en && !upper_q) |->
         (int'(mem_addr) >= RAM_BASE && int'(mem_addr) < RAM_BASE + ROWS))
      else $error("lower-region read outside packed RAM rows");

   assert_sfr_align_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_en && upper_q) |->
         (mem_addr[BIT_AW-1] && mem_addr[IDX_W-1:0] == '0))
      else $error("upper-region read not on an aligned register");

   assert_one_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |-> ($countones(mem_wdata ^ rbyte_q) <= 1))
      else $error("write changes more than one bit");

   assert_tclr_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_en && op_q == BOP_TCLR) |-> (!mem_wdata[idx_q] && bit_q))
      else $error("test-and-clear wrote wrongly");

   assert_ro_nowrite_R12: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |-> !(op_q inside {BOP_READ, BOP_RSV6, BOP_RSV7}))
      else $error("read-class op issued a write");

endmodule

// File: tb/sim_bitmem_access_unit.sv
`timescale 1ns/1ps
module sim_bitmem_access_unit;
   localparam int LAT = 2;

   typedef struct {
      logic [7:0] byte_a;
      logic       exp_bit;
      int         exp_lat;
      int         exp_wr;
      int         t0;
      string      tag;
      string      maptag;
   } sb_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic       req_ready;
   logic [2:0] req_op = 3'd0;
   logic [7:0] req_bit_addr = 8'd0;
   logic       req_carry = 1'b0;
   logic       done, bit_out;
   logic [7:0] mem_addr, mem_wdata, mem_rdata;
   logic       mem_rd_en, mem_wr_en;

   always #2.5 clk = ~clk;

   bitmem_access_unit #(.RD_LAT(LAT)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_op(req_op), .req_bit_addr(req_bit_addr), .req_carry(req_carry),
      .done(done), .bit_out(bit_out), .mem_addr(mem_addr), .mem_rd_en(mem_rd_en),
      .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

   // memory model with LAT cycles of read pipeline
   logic [7:0] mem [256];
   logic [7:0] pipe [LAT];
   logic [7:0] shadow [256];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < 256; k++) mem[k] <= 8'((k * 37 + 5) & 255);
         for (int k = 0; k < LAT; k++) pipe[k] <= 8'd0;
      end else begin
         if (mem_wr_en) mem[mem_addr] <= mem_wdata;
         if (mem_rd_en) pipe[0] <= mem[mem_addr];
         for (int k = 1; k < LAT; k++) pipe[k] <= pipe[k-1];
      end
   end
   assign mem_rdata = pipe[LAT-1];

   int n_tests = 0;
   int n_fail = 0;
   int cyc = 0;
   int wr_cnt = 0;
   bit finished = 0;
   sb_t q[$];

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // monitor: compares design activity against the scoreboard head
   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_rd_en) begin
            wr_cnt = 0;
            if (q.size() == 0) chk(0, "R13", "read with nothing pending", 1, 0);
            else chk(mem_addr == q[0].byte_a, q[0].maptag, "read byte address",
                     int'(mem_addr), int'(q[0].byte_a));
            chk(!mem_wr_en, "R13", "read and write together", 1, 0);
         end
         if (mem_wr_en) begin
            wr_cnt++;
            if (q.size() > 0)
               chk(mem_addr == q[0].byte_a, "R13", "write byte address",
                   int'(mem_addr), int'(q[0].byte_a));
         end
         if (done) begin
            if (q.size() == 0) begin
               chk(0, "R11", "done with nothing pending", 1, 0);
            end else begin
               sb_t it;
               it = q.pop_front();
               chk(bit_out == it.exp_bit, it.tag, "returned bit", int'(bit_out), int'(it.exp_bit));
               chk(cyc - it.t0 == it.exp_lat, it.tag, "latency", cyc - it.t0, it.exp_lat);
               chk(wr_cnt == it.exp_wr, it.tag, "write count", wr_cnt, it.exp_wr);
            end
         end
      end
   end

   // driver: predicts the result from the requirements, then issues the request
   task automatic do_op(input logic [2:0] op, input logic [7:0] ba, input logic c,
                        input string tag, input bit hold_busy);
      sb_t it;
      logic [7:0] b;
      logic [2:0] ix;
      logic old, nb;
      bit wr;
      b  = ba[7] ? {ba[7:3], 3'b000} : 8'h20 + {4'b0000, ba[6:3]};   // R2 / R3
      ix = ba[2:0];
      old = shadow[b][ix];
      case (op)
         3'd1: nb = 1'b1;
         3'd2: nb = 1'b0;
         3'd3: nb = ~old;
         3'd4: nb = c;
         3'd5: nb = 1'b0;
         default: nb = old;
      endcase
      wr = (op inside {3'd1, 3'd2, 3'd3, 3'd4}) || (op == 3'd5 && old);
      if (wr) shadow[b][ix] = nb;
      it.byte_a  = b;
      it.exp_bit = old;
      it.exp_lat = wr ? LAT + 2 : LAT + 1;
      it.exp_wr  = wr ? 1 : 0;
      it.tag     = tag;
      it.maptag  = ba[7] ? "R3" : "R2";
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_op = op; req_bit_addr = ba; req_carry = c;
      @(posedge clk);
      #1;
      it.t0 = cyc;
      q.push_back(it);
      if (hold_busy) begin
         // R11: a competing request held while busy must be ignored
         req_op = 3'd1; req_bit_addr = ba ^ 8'h01;
         for (int k = 0; k < LAT; k++) begin
            @(negedge clk);
            chk(!req_ready, "R11", "ready while busy", int'(req_ready), 0);
         end
         req_valid = 1'b0;
      end else begin
         @(negedge clk);
         req_valid = 1'b0;
         req_carry = ~c;   // R8: later carry changes must not matter
      end
      while (q.size() != 0) @(negedge clk);
   endtask

   initial begin
      for (int k = 0; k < 256; k++) shadow[k] = 8'((k * 37 + 5) & 255);
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(req_ready === 1'b1, "R1", "ready after reset", int'(req_ready), 1);
      chk(done === 1'b0 && mem_rd_en === 1'b0 && mem_wr_en === 1'b0, "R1",
          "strobes after reset", int'({done, mem_rd_en, mem_wr_en}), 0);

      do_op(3'd0, 8'h00, 1'b0, "R4", 0);   // R2 lowest bit
      do_op(3'd0, 8'h7F, 1'b0, "R4", 0);   // R2 highest packed bit
      do_op(3'd0, 8'h80, 1'b0, "R4", 0);   // R3
      do_op(3'd0, 8'hFF, 1'b0, "R4", 0);   // R3
      do_op(3'd0, 8'hD7, 1'b0, "R4", 0);   // R3
      do_op(3'd1, 8'h0B, 1'b0, "R5", 0);
      do_op(3'd0, 8'h0B, 1'b0, "R5", 0);
      do_op(3'd1, 8'hE1, 1'b0, "R5", 0);
      do_op(3'd2, 8'h0B, 1'b0, "R6", 0);
      do_op(3'd2, 8'hE5, 1'b0, "R6", 0);
      do_op(3'd3, 8'h42, 1'b0, "R7", 0);
      do_op(3'd3, 8'h42, 1'b0, "R7", 0);
      do_op(3'd3, 8'hB4, 1'b0, "R7", 0);
      do_op(3'd4, 8'h33, 1'b1, "R8", 0);
      do_op(3'd0, 8'h33, 1'b0, "R8", 0);
      do_op(3'd4, 8'h33, 1'b0, "R8", 0);
      do_op(3'd0, 8'h33, 1'b0, "R8", 0);
      do_op(3'd4, 8'h99, 1'b1, "R8", 0);
      do_op(3'd1, 8'h55, 1'b0, "R9", 0);
      do_op(3'd5, 8'h55, 1'b0, "R9", 0);
      do_op(3'd5, 8'h55, 1'b0, "R10", 0);
      do_op(3'd0, 8'h55, 1'b0, "R10", 0);
      do_op(3'd2, 8'hC2, 1'b0, "R10", 0);
      do_op(3'd5, 8'hC2, 1'b0, "R10", 0);
      do_op(3'd6, 8'h60, 1'b1, "R12", 0);
      do_op(3'd7, 8'hF1, 1'b0, "R12", 0);
      do_op(3'd2, 8'h11, 1'b0, "R11", 0);
      do_op(3'd1, 8'h10, 1'b0, "R11", 1);
      do_op(3'd0, 8'h11, 1'b0, "R11", 0);  // held request left this bit untouched

      // untouched bits and bytes: whole store against the prediction (R5 R6 R7)
      begin
         int bad;
         int first;
         bad = 0;
         first = -1;
         for (int k = 0; k < 256; k++)
            if (mem[k] !== shadow[k]) begin
               bad++;
               if (first < 0) first = k;
            end
         chk(bad == 0, "R5", "bytes differing from prediction", bad, 0);
      end

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL R11 watchdog: actual %0d expected %0d", 1, 0);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule